// File: doc/BRIEF.md
# Programmable Countdown Timer with Power-of-Two Prescaler

This block counts down from a software-loaded start value, stepping once for every N bus cycles. N is a power of two chosen by a small divide register. A control entry selects one-shot or auto-reload operation, holds an 8-bit interrupt vector and carries a mask bit. Each time the count reaches zero, a pending-expiry counter goes up. While that counter is non-zero and the timer is neither masked nor disabled, the block raises a request that carries the entry's vector. Each cycle in which the consumer acknowledges that request takes one expiry off the counter.

Software reaches the block through a single-cycle write port with a 2-bit register select. The select codes are 0 for the start value, 1 for the divide register, 2 for the control entry and 3 for the enable register. The remaining count can be read at any time. The control entry and the enable register are also visible as outputs. The `bus_tick` input is a qualifier that marks each bus cycle, so the timer can run slower than `clk`.

Top module: `local_timer`

## Requirements
- R1: After reset, `cur_count` and `pend_count` are 0, `irq_req` is low, `tmr_entry` reads 0x0001_0000 (masked, one-shot, vector 0), and `swen_reg` reads 0x0FF (enable bit clear).
- R2: The divide register keeps bits 3..0 of the write. A 3-bit code is formed as {bit 3, bit 1, bit 0}, and bit 2 has no effect. The divisor is 2^((code+1) mod 8), so code 7 divides by 1, code 0 by 2 and code 6 by 128.
- R3: While the count is non-zero, it drops by one for every divisor `bus_tick` cycles and holds when `bus_tick` is low. After k ticks from a start value N, it reads N - floor(k/divisor), so one period is N × divisor ticks.
- R4: Writing the start value (select 0) abandons any countdown in progress. The count is loaded with the written value and the prescaler phase starts from zero.
- R5: Writing a start value of 0 stops the timer. The count then reads 0 and no expiry follows.
- R6: With entry bit 17 clear (one-shot), the count stays at 0 after it expires and `pend_count` rises by exactly one.
- R7: With entry bit 17 set (periodic), the count reloads the start value on expiry, and `pend_count` rises once for every period.
- R8: `irq_req` is high exactly when `pend_count` is non-zero, `unit_en` is high, enable bit 8 is set and entry bit 16 (mask) is clear. `irq_vector` equals entry bits 7..0. `pend_count` drops by one on each cycle with `irq_req` and `irq_ack` both high, and an acknowledge without a request changes nothing.
- R9: The enable register keeps only bits 9..0 of a write. A write with bit 8 clear sets the entry's mask bit and clears `pend_count`.
- R10: An entry write keeps only bits 17, 16, 12 and 7..0. While enable bit 8 is clear, the written entry has bit 16 forced to 1.
- R11: A divide-register write while the timer runs does not disturb the current prescaler phase. The new divisor applies from the next count step onward.
- R12: With the default parameters, `pend_count` saturates at 15 rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_tick | input | 1 | One bus cycle elapsed (prescaler input) |
| unit_en | input | 1 | Global unit enable, gates the request |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 start value, 1 divide, 2 entry, 3 enable |
| wr_data | input | 32 | Write data |
| irq_ack | input | 1 | Consumer took the request this cycle |
| cur_count | output | CNT_W | Remaining count in the current period |
| pend_count | output | PEND_W | Expiries not yet delivered |
| irq_req | output | 1 | Timer interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| tmr_entry | output | 32 | Stored control entry |
| swen_reg | output | 32 | Stored enable register (bits 9..0) |

## Verification
The bench walks every divide code, including one with bit 2 set. A decoder that used contiguous bits, or that did not wrap code 7 to a divisor of 1, would read back the wrong remaining count. It changes the divisor in the middle of a prescaler period and checks the count at the old boundary and just after it; a design that switched at once would step early. It drives one-shot and periodic expiries, acknowledges with and without a request, and clears the enable to see the mask forced and the pending counter emptied. It also drives enough rapid periodic expiries to hit the pending ceiling, where a wrapping counter would fall back to zero and lose the request.

// File: rtl/lt_pkg.sv
package lt_pkg;

   // Register select codes on the write port
   typedef enum logic [1:0] {
      SEL_START  = 2'd0,
      SEL_DIVIDE = 2'd1,
      SEL_ENTRY  = 2'd2,
      SEL_ENABLE = 2'd3
   } lt_sel_e;

   localparam int SHIFT_W   = 3;
   localparam int PRESC_W   = (1 << SHIFT_W) - 1;   // largest divisor 2^7
   localparam int ENT_MASK  = 16;
   localparam int ENT_PERIOD = 17;
   localparam int EN_BIT    = 8;
   localparam logic [31:0] ENTRY_KEEP  = 32'h0003_10FF;
   localparam logic [31:0] ENABLE_KEEP = 32'h0000_03FF;
   localparam logic [31:0] ENTRY_RST   = 32'h0001_0000;
   localparam logic [31:0] ENABLE_RST  = 32'h0000_00FF;

   // {bit3, bit1, bit0} + 1, wrapping within three bits
   function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] raw);
      logic [SHIFT_W-1:0] code;
      code = {raw[3], raw[1], raw[0]};
      return code + 3'd1;
   endfunction

endpackage

// File: rtl/lt_prescaler.sv
module lt_prescaler
   import lt_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               active,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift_cfg,
   output logic               boundary
);

   logic [PRESC_W-1:0] phase;
   logic [SHIFT_W-1:0] shift_act;
   logic [PRESC_W-1:0] limit;

   assign limit    = ~({PRESC_W{1'b1}} << shift_act);
   assign boundary = tick & active & ~restart & (phase == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= '0;
         shift_act <= div_shift(4'h0);
      end else if (restart || !active) begin
         phase     <= '0;
         shift_act <= shift_cfg;
      end else if (tick) begin
         if (phase == limit) begin
            phase     <= '0;
            shift_act <= shift_cfg;   // new divisor from this boundary on
         end else begin
            phase <= phase + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lt_downcount.sv
module lt_downcount #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  logic             periodic,
   input  logic [CNT_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             expire
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   assign expire = step & ~load & (count == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (load) begin
         count <= load_val;
      end else if (step) begin
         if (count == LAST)
            count <= periodic ? reload_val : '0;
         else
            count <= count - LAST;
      end
   end

endmodule

// File: rtl/lt_pending.sv
module lt_pending #(
   parameter int PEND_W   = 4,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic              dec,
   input  logic              clr,
   output logic [PEND_W-1:0] cnt
);

   logic at_ceiling;

   generate
      if (SATURATE) begin : g_sat
         assign at_ceiling = &cnt;
      end else begin : g_wrap
         assign at_ceiling = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   if (!at_ceiling) cnt <= cnt + 1'b1;
            2'b01:   if (cnt != '0)   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

endmodule

// File: rtl/local_timer.sv
module local_timer
   import lt_pkg::*;
#(
   parameter int CNT_W         = 32,
   parameter int PEND_W        = 4,
   parameter bit PEND_SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_tick,
   input  logic              unit_en,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   input  logic              irq_ack,
   output logic [CNT_W-1:0]  cur_count,
   output logic [PEND_W-1:0] pend_count,
   output logic              irq_req,
   output logic [7:0]        irq_vector,
   output logic [31:0]       tmr_entry,
   output logic [31:0]       swen_reg
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
         $error("local_timer: CNT_W must be within 2..32");
      end
      if (PEND_W < 1 || PEND_W > 16) begin : g_bad_pend
         $error("local_timer: PEND_W must be within 1..16");
      end
   endgenerate

   logic [3:0]       div_q;
   logic [CNT_W-1:0] start_q;
   logic [31:0]      entry_q;
   logic [31:0]      enable_q;

   logic wr_start, wr_div, wr_entry, wr_enable;
   logic disable_wr, step, expire, deliver, sw_on;

   assign wr_start   = wr_en && (lt_sel_e'(wr_sel) == SEL_START);
   assign wr_div     = wr_en && (lt_sel_e'(wr_sel) == SEL_DIVIDE);
   assign wr_entry   = wr_en && (lt_sel_e'(wr_sel) == SEL_ENTRY);
   assign wr_enable  = wr_en && (lt_sel_e'(wr_sel) == SEL_ENABLE);
   assign disable_wr = wr_enable && !wr_data[EN_BIT];
   assign sw_on      = enable_q[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q    <= '0;
         start_q  <= '0;
         entry_q  <= ENTRY_RST;
         enable_q <= ENABLE_RST;
      end else begin
         if (wr_div)   div_q   <= wr_data[3:0];
         if (wr_start) start_q <= wr_data[CNT_W-1:0];
         if (wr_enable) begin
            enable_q <= wr_data & ENABLE_KEEP;
            if (!wr_data[EN_BIT]) entry_q[ENT_MASK] <= 1'b1;
         end
         if (wr_entry) begin
            entry_q <= (wr_data & ENTRY_KEEP) |
                       (sw_on ? 32'h0 : (32'h1 << ENT_MASK));
         end
      end
   end

   lt_prescaler u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (bus_tick),
      .active    (cur_count != '0),
      .restart   (wr_start),
      .shift_cfg (div_shift(div_q)),
      .boundary  (step)
   );

   lt_downcount #(.CNT_W(CNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (wr_start),
      .load_val   (wr_data[CNT_W-1:0]),
      .step       (step),
      .periodic   (entry_q[ENT_PERIOD]),
      .reload_val (start_q),
      .count      (cur_count),
      .expire     (expire)
   );

   lt_pending #(.PEND_W(PEND_W), .SATURATE(PEND_SATURATE)) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (expire),
      .dec   (deliver),
      .clr   (disable_wr),
      .cnt   (pend_count)
   );

   assign irq_req    = (pend_count != '0) && unit_en && sw_on && !entry_q[ENT_MASK];
   assign deliver    = irq_req && irq_ack;
   assign irq_vector = entry_q[7:0];
   assign tmr_entry  = entry_q;
   assign swen_reg   = enable_q;

endmodule

// File: rtl/lt_timer_chk.sv
module lt_timer_chk #(
   parameter int CNT_W  = 32,
   parameter int PEND_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [31:0]       wr_data,
   input logic [CNT_W-1:0]  cur_count,
   input logic [PEND_W-1:0] pend_count,
   input logic              irq_req,
   input logic [31:0]       tmr_entry,
   input logic [31:0]       swen_reg
);

   // R4: a start-value write is visible in the count on the next cycle
   assert_start_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> (cur_count == $past(wr_data[CNT_W-1:0])));

   // R5: a stopped timer stays stopped until the start value is rewritten
   assert_stopped_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_count == '0 && !(wr_en && wr_sel == 2'd0)) |=> (cur_count == '0));

   // R9: disabling masks the entry and empties the pending counter
   assert_disable_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd3 && !wr_data[8]) |=> (tmr_entry[16] && pend_count == '0));

   // R10: entry writes while disabled come out masked and trimmed
   assert_entry_forced_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2 && !swen_reg[8]) |=>
         (tmr_entry[16] && (tmr_entry & ~32'h0003_10FF) == 32'h0));

   // R8: a request needs something pending
   assert_req_needs_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (pend_count != '0));

endmodule

bind local_timer lt_timer_chk #(.CNT_W(CNT_W), .PEND_W(PEND_W)) u_lt_timer_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .cur_count  (cur_count),
   .pend_count (pend_count),
   .irq_req    (irq_req),
   .tmr_entry  (tmr_entry),
   .swen_reg   (swen_reg)
);

// File: tb/test_local_timer.sv
`timescale 1ns/1ps
module test_local_timer;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_tick = 1'b1;
   logic        unit_en = 1'b1;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'h0;
   logic        irq_ack = 1'b0;
   logic [31:0] cur_count;
   logic [3:0]  pend_count;
   logic        irq_req;
   logic [7:0]  irq_vector;
   logic [31:0] tmr_entry;
   logic [31:0] swen_reg;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;   // 125 MHz

   local_timer i_local_timer (
      .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .unit_en(unit_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .irq_ack(irq_ack),
      .cur_count(cur_count), .pend_count(pend_count), .irq_req(irq_req),
      .irq_vector(irq_vector), .tmr_entry(tmr_entry), .swen_reg(swen_reg)
   );

   // divide value, start value, ticks to wait, expected remaining count
   localparam int NROW = 9;
   localparam int V_DIV [NROW]  = '{'hB, 'h0, 'h1, 'h2, 'h3, 'h7, 'h8, 'h9, 'hA};
   localparam int V_INIT[NROW]  = '{100, 100, 50, 50, 20, 20, 10, 10, 5};
   localparam int V_WAIT[NROW]  = '{37, 37, 10, 20, 33, 33, 65, 130, 300};
   localparam int V_EXP [NROW]  = '{63, 82, 48, 48, 18, 18, 8, 8, 3};

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic step(input int k);
      repeat (k) @(negedge clk);
   endtask

   task automatic ack(input int k);
      irq_ack = 1'b1;
      step(k);
      irq_ack = 1'b0;
   endtask

   task automatic summary;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);

      // R1 reset state
      check("R1 count", cur_count, 32'h0);
      check("R1 pending", {28'h0, pend_count}, 32'h0);
      check("R1 req", {31'h0, irq_req}, 32'h0);
      check("R1 entry", tmr_entry, 32'h0001_0000);
      check("R1 enable", swen_reg, 32'h0000_00FF);

      // R2 / R3: every divide code from the table
      for (int i = 0; i < NROW; i++) begin
         wr(2'd1, V_DIV[i]);
         wr(2'd0, V_INIT[i]);
         step(V_WAIT[i]);
         check($sformatf("R2 R3 row %0d", i), cur_count, V_EXP[i]);
      end

      // R3: count holds while bus_tick is low
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd10);
      step(2);
      bus_tick = 1'b0;
      step(5);
      check("R3 hold without tick", cur_count, 32'd8);
      bus_tick = 1'b1;
      step(1);
      check("R3 resume", cur_count, 32'd7);

      // R4: rewriting the start value restarts the countdown
      wr(2'd0, 32'd10);
      step(4);
      wr(2'd0, 32'd10);
      step(2);
      check("R4 restart", cur_count, 32'd8);

      // R5: start value 0 stops the timer
      wr(2'd0, 32'd0);
      step(5);
      check("R5 stopped", cur_count, 32'd0);

      // R6: one-shot expiry, delivery
      wr(2'd3, 32'h0FF);
      wr(2'd3, 32'h1FF);
      wr(2'd2, 32'h42);
      wr(2'd0, 32'd5);
      step(5);
      check("R6 one-shot pending", {28'h0, pend_count}, 32'd1);
      check("R8 req raised", {31'h0, irq_req}, 32'd1);
      check("R8 vector", {24'h0, irq_vector}, 32'h42);
      step(10);
      check("R6 stays at zero", cur_count, 32'd0);
      check("R6 single expiry", {28'h0, pend_count}, 32'd1);
      ack(1);
      check("R8 ack drains", {28'h0, pend_count}, 32'd0);
      check("R8 req dropped", {31'h0, irq_req}, 32'd0);

      // R7: periodic reload
      wr(2'd2, 32'h2_0042);
      wr(2'd0, 32'd4);
      step(4);
      check("R7 first expiry", {28'h0, pend_count}, 32'd1);
      check("R7 reloaded", cur_count, 32'd4);
      step(4);
      check("R7 second expiry", {28'h0, pend_count}, 32'd2);
      step(2);
      check("R7 mid period", cur_count, 32'd2);
      wr(2'd0, 32'd0);
      ack(2);
      check("R8 two acks", {28'h0, pend_count}, 32'd0);

      // R8: mask and unit enable gate the request
      wr(2'd2, 32'h1_0042);
      wr(2'd0, 32'd3);
      step(3);
      check("R8 masked pending", {28'h0, pend_count}, 32'd1);
      check("R8 masked no req", {31'h0, irq_req}, 32'd0);
      ack(1);
      check("R8 ack without req ignored", {28'h0, pend_count}, 32'd1);
      wr(2'd2, 32'h42);
      check("R8 unmasked req", {31'h0, irq_req}, 32'd1);
      unit_en = 1'b0;
      step(1);
      check("R8 unit disabled", {31'h0, irq_req}, 32'd0);
      unit_en = 1'b1;

      // R9: disabling masks the entry and clears pending
      wr(2'd3, 32'h0FF);
      check("R9 entry masked", tmr_entry, 32'h0001_0042);
      check("R9 pending cleared", {28'h0, pend_count}, 32'd0);

      // R10: entry writes while disabled, field trimming
      wr(2'd2, 32'h42);
      check("R10 forced mask", tmr_entry, 32'h0001_0042);
      wr(2'd3, 32'hFFFF_FFFF);
      check("R9 low ten bits", swen_reg, 32'h0000_03FF);
      wr(2'd2, 32'hFFFF_FFFF);
      check("R10 kept fields", tmr_entry, 32'h0003_10FF);

      // R11: divide change waits for the next boundary
      wr(2'd2, 32'h1_0000);
      wr(2'd1, 32'h3);
      wr(2'd0, 32'd100);
      step(4);
      wr(2'd1, 32'hB);
      step(11);
      check("R11 old divisor to boundary", cur_count, 32'd99);
      step(3);
      check("R11 new divisor after", cur_count, 32'd96);

      // R12: pending saturates
      wr(2'd3, 32'h0FF);
      wr(2'd3, 32'h1FF);
      wr(2'd2, 32'h3_0000);
      wr(2'd1, 32'hB);
      wr(2'd0, 32'd1);
      step(20);
      check("R12 saturation", {28'h0, pend_count}, 32'd15);
      wr(2'd0, 32'd0);

      summary();
   end

endmodule